// File: doc/BRIEF.md
# Pipelined Trinomial Montgomery Multiplier over GF(2^M)

This block multiplies two elements of the binary field GF(2^M) in polynomial basis and returns the Montgomery product D = A·B·x^(-N) mod P, with P = x^M + x^N + 1. The trinomial is fixed when the block is elaborated. It must be irreducible, and M and N must have no common factor. Elaboration stops with an error if gcd(M, N) is not 1.

The datapath is a systolic array of M rows by M columns. Row j of column c forms one partial product, a_j·b_s with s = (c+N-j) mod M, and adds it into a running cyclic sum k_c. That sum is A·B·x^(-N) mod (x^M+1). Some cells also add their partial product into a second running sum. That second sum collects the correction polynomial G = T1 + T3·x^N, where T = A·B = T1 + T2·x^N + T3·x^(M+N). The final registered row adds each G coefficient to the matching K coefficient. One operand pair can enter on every clock, and each result leaves M+1 clocks later.

The block is meant to sit inside field arithmetic units, such as point arithmetic for curve cryptography, where the operands are already held in the Montgomery domain.

Top module: `gfm_trinomial_mont`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high on a clock edge, `out_valid` and `d_out` are 0 after that edge.
- R2: An operand pair sampled with `in_valid` high produces its result with `out_valid` high exactly M+1 rising edges later, counting the sampling edge. `out_valid` is low in every other cycle.
- R3: Bit i of `a_in`, `b_in` and `d_out` is the coefficient of x^i. The result is D = A·B·x^(-N) mod (x^M + x^N + 1).
- R4: If either operand is 0, the result is 0.
- R5: When A = x^N the result equals B. When B = x^N the result equals A.
- R6: A new operand pair is accepted on every clock. Results come out on consecutive clocks, in the order their operands entered.
- R7: A reset that arrives while results are in flight discards them. None of them raises `out_valid` afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `a_in`/`b_in` are valid this cycle |
| a_in | input | M | Operand A, bit i = coefficient of x^i |
| b_in | input | M | Operand B, bit i = coefficient of x^i |
| out_valid | output | 1 | `d_out` holds a result |
| d_out | output | M | Montgomery product D |

## Verification
A fault in one cell corrupts only the coefficients whose column passes through that cell, and only for operand pairs that exercise that cell's partial product. Random back-to-back operands therefore expose it within a few results at M+1 cycles of latency. A misplaced correction tap flips a coefficient only when the low or high coefficient products are non-zero. For that reason the x^N identity operands and dense random operands are both compared against a bit-serial reference. A broken valid pipeline shows up as an `out_valid` that is early, late or missing, which is checked on every clock, including the cycles after a reset in mid-stream.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

  // Greatest common divisor, used for the elaboration check.
  function automatic int gcd_f(input int x, input int y);
    int u;
    int v;
    u = x;
    v = y;
    while (v != 0) begin
      int t;
      t = u % v;
      u = v;
      v = t;
    end
    return u;
  endfunction

  // Index of the B coefficient consumed by the cell at row j, column c.
  function automatic int b_index(input int j, input int c, input int m, input int n);
    return (c + n - j + m) % m;
  endfunction

  // Whether the partial product of cell (j, c) also belongs to the correction polynomial.
  // Column c gathers products a_r*b_s with r+s = c+n (mod m).
  // For c >= m-n the correction term is r+s = c+n-m (low product coefficient).
  // For c <= m-n-2 the correction term is r+s = c+n+m (high product coefficient).
  function automatic bit cell_taps(input int j, input int c, input int m, input int n);
    int v;
    v = j + b_index(j, c, m, n);
    if (c >= m - n)          return bit'(v == c + n - m);
    else if (c <= m - n - 2) return bit'(v == c + n + m);
    else                     return 1'b0;
  endfunction

  // Column whose correction chain carries g_i.
  function automatic int g_column(input int i, input int m, input int n);
    return (i - n + m) % m;
  endfunction

endpackage

// File: rtl/gfm_cell.sv
module gfm_cell #(
  parameter bit HAS_G = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic a_bit,
  input  logic b_bit,
  input  logic k_in,
  input  logic g_in,
  output logic k_out,
  output logic g_out
);
  logic prod;
  assign prod = a_bit & b_bit;

  always_ff @(posedge clk) begin
    if (rst) k_out <= 1'b0;
    else     k_out <= k_in ^ prod;
  end

  generate
    if (HAS_G) begin : g_tap
      always_ff @(posedge clk) begin
        if (rst) g_out <= 1'b0;
        else     g_out <= g_in ^ prod;
      end
    end else begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) g_out <= 1'b0;
        else     g_out <= g_in;
      end
    end
  endgenerate

  AST_CELL_RST: assert property (@(posedge clk) rst |=> (k_out == 1'b0 && g_out == 1'b0)); // R1
  AST_CELL_KHOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && !(a_bit && b_bit)) |=> (k_out == $past(k_in))); // R3
  AST_CELL_GHOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && !(a_bit && b_bit)) |=> (g_out == $past(g_in))); // R3

endmodule

// File: rtl/gfm_sum_row.sv
module gfm_sum_row #(
  parameter int M = 7,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] k_vec,
  input  logic [M-1:0] g_vec,
  output logic [M-1:0] d_out
);
  import gfm_pkg::*;

  logic [M-1:0] d_next;

  generate
    for (genvar i = 0; i < M; i++) begin : g_col
      if (i < M - 1) begin : g_add
        assign d_next[i] = k_vec[i] ^ g_vec[g_column(i, M, N)];
      end else begin : g_top
        assign d_next[i] = k_vec[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) d_out <= '0;
    else     d_out <= d_next;
  end

  AST_SUM_RST: assert property (@(posedge clk) rst |=> (d_out == '0)); // R1
  AST_SUM_TOP: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (d_out[M-1] == $past(k_vec[M-1]))); // R3

endmodule

// File: rtl/gfm_trinomial_mont.sv
module gfm_trinomial_mont #(
  parameter int M = 7,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] b_in,
  output logic         out_valid,
  output logic [M-1:0] d_out
);
  import gfm_pkg::*;

  localparam int ROWS = M;
  localparam int LAT  = M + 1;

  generate
    if (N < 1 || N >= M || gcd_f(M, N) != 1) begin : g_bad_params
      $error("gfm_trinomial_mont: N must lie in 1..M-1 and be coprime to M");
    end
  endgenerate

  // Operand skew: stage j feeds row j.
  logic [M-1:0] a_stg [0:ROWS-1];
  logic [M-1:0] b_stg [0:ROWS-1];
  assign a_stg[0] = a_in;
  assign b_stg[0] = b_in;

  generate
    for (genvar j = 1; j < ROWS; j++) begin : g_skew
      always_ff @(posedge clk) begin
        if (rst) begin
          a_stg[j] <= '0;
          b_stg[j] <= '0;
        end else begin
          a_stg[j] <= a_stg[j-1];
          b_stg[j] <= b_stg[j-1];
        end
      end
    end
  endgenerate

  // Accumulator chains per column.
  logic [M-1:0] k_acc [0:ROWS];
  logic [M-1:0] g_acc [0:ROWS];
  assign k_acc[0] = '0;
  assign g_acc[0] = '0;

  generate
    for (genvar j = 0; j < ROWS; j++) begin : g_row
      for (genvar c = 0; c < M; c++) begin : g_colm
        gfm_cell #(
          .HAS_G(cell_taps(j, c, M, N))
        ) u_cell (
          .clk  (clk),
          .rst  (rst),
          .a_bit(a_stg[j][j]),
          .b_bit(b_stg[j][b_index(j, c, M, N)]),
          .k_in (k_acc[j][c]),
          .g_in (g_acc[j][c]),
          .k_out(k_acc[j+1][c]),
          .g_out(g_acc[j+1][c])
        );
      end
    end
  endgenerate

  gfm_sum_row #(
    .M(M),
    .N(N)
  ) u_sum (
    .clk  (clk),
    .rst  (rst),
    .k_vec(k_acc[ROWS]),
    .g_vec(g_acc[ROWS]),
    .d_out(d_out)
  );

  // Valid pipeline matching the M rows plus the sum row.
  logic [LAT-1:0] vld;
  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[LAT-2:0], in_valid};
  end
  assign out_valid = vld[LAT-1];

  AST_VALID_RST: assert property (@(posedge clk) rst |=> !out_valid); // R1
  AST_VALID_SRC: assert property (@(posedge clk) disable iff (rst)
    (!rst && vld == '0 && !in_valid) |=> !out_valid); // R2
  AST_DRAIN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!rst && k_acc[ROWS] == '0 && g_acc[ROWS] == '0) |=> (d_out == '0)); // R4

endmodule

// File: tb/tb_gfm_trinomial_mont.sv
module tb_gfm_trinomial_mont;
  localparam int M = 7;
  localparam int N = 3;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = M + 1;
  localparam logic [M:0] POLY = (M+1)'(1) << M | (M+1)'(1) << N | (M+1)'(1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [M-1:0] a_in = '0;
  logic [M-1:0] b_in = '0;
  logic out_valid;
  logic [M-1:0] d_out;

  int checks = 0;
  int failures = 0;
  bit started = 1'b0;
  bit done = 1'b0;
  string cur_tag = "R3";

  gfm_trinomial_mont #(.M(M), .N(N)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_in(a_in), .b_in(b_in), .out_valid(out_valid), .d_out(d_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bit-serial reference: A*B mod P, then n divisions by x.
  function automatic logic [M-1:0] ref_mont(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M:0] r;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = r << 1;
      if (r[M]) r = r ^ POLY;
      if (b[i]) r = r ^ {1'b0, a};
    end
    for (int k = 0; k < N; k++) begin
      if (r[0]) r = r ^ POLY;
      r = r >> 1;
    end
    return r[M-1:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural pipeline model of expected outputs.
  bit           qv [0:LAT-1];
  logic [M-1:0] qd [0:LAT-1];
  string        qt [0:LAT-1];

  initial begin
    for (int k = 0; k < LAT; k++) begin
      qv[k] = 1'b0; qd[k] = '0; qt[k] = "R2";
    end
  end

  always @(posedge clk) begin
    for (int k = LAT - 1; k > 0; k--) begin
      qv[k] = qv[k-1]; qd[k] = qd[k-1]; qt[k] = qt[k-1];
    end
    qv[0] = in_valid && !rst;
    qd[0] = ref_mont(a_in, b_in);
    qt[0] = cur_tag;
    if (rst) begin
      for (int k = 0; k < LAT; k++) qv[k] = 1'b0;
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check(out_valid == qv[LAT-1], {qt[LAT-1], " R2 valid"}, {{(M-1){1'b0}}, out_valid},
            {{(M-1){1'b0}}, qv[LAT-1]});
      if (qv[LAT-1] && out_valid)
        check(d_out == qd[LAT-1], qt[LAT-1], d_out, qd[LAT-1]);
    end
  end

  task automatic drive(input bit v, input logic [M-1:0] a, input logic [M-1:0] b, input string tag);
    @(negedge clk);
    in_valid = v; a_in = a; b_in = b; cur_tag = tag;
  endtask

  task automatic idle(input int cyc);
    for (int k = 0; k < cyc; k++) drive(1'b0, '0, '0, "R2");
  endtask

  logic [M-1:0] xn;

  initial begin
    xn = M'(1) << N;
    repeat (3) @(negedge clk);
    // R1: reset state.
    check(out_valid == 1'b0, "R1 out_valid", {{(M-1){1'b0}}, out_valid}, '0);
    check(d_out == '0, "R1 d_out", d_out, '0);
    rst = 1'b0;

    // R5: x^N behaves as the Montgomery one.
    drive(1'b1, xn, 7'h5b, "R5");
    drive(1'b1, 7'h26, xn, "R5");
    drive(1'b1, xn, '1, "R5");
    // R4: zero operands.
    drive(1'b1, '0, 7'h7f, "R4");
    drive(1'b1, 7'h33, '0, "R4");
    // R3: corner operands.
    drive(1'b1, 7'h40, 7'h40, "R3");
    drive(1'b1, '1, '1, "R3");
    drive(1'b1, 7'h01, 7'h01, "R3");
    idle(LAT + 1);

    // R6: back-to-back random stream.
    for (int k = 0; k < 60; k++) drive(1'b1, M'($urandom), M'($urandom), "R6");
    // R2: sparse valid pattern.
    for (int k = 0; k < 40; k++) drive(k % 3 == 0, M'($urandom), M'($urandom), "R2");
    idle(LAT + 1);

    // R7: reset with results in flight.
    for (int k = 0; k < 4; k++) drive(1'b1, M'($urandom), M'($urandom), "R7");
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1; cur_tag = "R7";
    @(negedge clk);
    rst = 1'b0;
    idle(LAT + 2);

    // R3: random operands after recovery.
    for (int k = 0; k < 40; k++) drive(1'b1, M'($urandom), M'($urandom), "R3");
    idle(LAT + 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule